// File: doc/BRIEF.md
# System-Call Dispatch Sequencer

This block carries out the system-call instruction of a small 16-bit processor. When decode presents a trap, the block takes the 8-bit service number and the program counter that fetch has already advanced. It uses the service number as the address of an entry in a 256-entry table held in memory, and reads that entry through a single request/valid memory port. In one cycle it then writes the saved program counter into link register 7 and loads the program counter with the entry it read. Control passes to the service routine, and the routine can later return to the instruction after the trap.

The same sequencer also handles the return instruction. It takes the value that the register file presents for register 7 and loads it into the program counter. It raises a busy flag for as long as a sequence is running. A one-cycle completion pulse tells the pipeline when it may resume.

Top module: `trap_dispatch_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `mem_req`, `reg_we` and `pc_ld` are all 0.
- R2: A `trap_start` seen while idle produces `mem_req` for exactly one cycle, in the next cycle. During that cycle `mem_addr` is the 8-bit `trap_vec` zero-extended to 16 bits, so it falls in 0x0000 to 0x00FF.
- R3: After the request the block waits any number of cycles for `mem_valid`. While it waits, `pc_ld`, `reg_we` and `done` stay 0. `mem_valid` is only taken in the cycles after the request cycle.
- R4: In the cycle after `mem_valid` is sampled, `pc_ld` and `reg_we` are both 1 for one cycle. `pc_val` equals the `mem_rdata` word that was sampled, `reg_waddr` is 7, and `reg_wdata` is the `pc_next` captured when the trap started.
- R5: `done` is 1 for exactly one cycle, in the cycle after the program counter load. The block is idle again in the cycle after that.
- R6: `busy` is 1 from the request cycle (or the return jump cycle) through the `done` cycle, and 0 otherwise.
- R7: A `trap_start` or `ret_start` that arrives while `busy` is 1 has no effect. No extra memory request is made, and the table address and the saved return address stay unchanged.
- R8: A `ret_start` seen while idle produces, in the next cycle, `pc_ld`=1 with `pc_val` equal to the `r7_val` sampled with the start. In that cycle `reg_we` and `mem_req` stay 0. `done` follows one cycle later.
- R9: When `trap_start` and `ret_start` are both 1 in the same idle cycle, the trap is carried out and the return is dropped.
- R10: The link value written to register 7 is the `pc_next` sampled at the trap start. Changes on `pc_next` during the sequence do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_start | input | 1 | Decoded system-call instruction, one-cycle pulse |
| trap_vec | input | 8 | Service number |
| pc_next | input | 16 | Already-incremented program counter |
| ret_start | input | 1 | Decoded return instruction, one-cycle pulse |
| r7_val | input | 16 | Current content of register 7 |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 16 | Table read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data word |
| reg_we | output | 1 | Register-file write strobe |
| reg_waddr | output | 3 | Register-file write index |
| reg_wdata | output | 16 | Register-file write data |
| pc_ld | output | 1 | Program counter load strobe |
| pc_val | output | 16 | New program counter value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete, one-cycle pulse |

## Verification
The inline assertions check, on every cycle, the properties that hold at any moment. The request lasts one cycle and implies busy. Any register write comes together with a program counter load to index 7. Done always follows a load. No load occurs while the block is still waiting for memory. The saved link address stays stable while the read is outstanding. The bench's scenarios are needed for the value-level behaviour. They show that the table address is the zero-extended service number at both ends of the range. They show that the program counter receives the word that was fetched, and that the link value is the one sampled at the start even when `pc_next` moves. They also cover starts arriving mid-sequence that must be dropped, and the tie between a trap and a return that arrive together.

// File: rtl/trapseq_pkg.sv
package trapseq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_REQ  = 3'd1,
      ST_WAIT = 3'd2,
      ST_LINK = 3'd3,
      ST_JUMP = 3'd4,
      ST_DONE = 3'd5
   } tseq_state_e;
endpackage

// File: rtl/tseq_vec_addr.sv
module tseq_vec_addr #(
   parameter int VEC_W      = 8,
   parameter int ADDR_W     = 16,
   parameter int TABLE_BASE = 0
) (
   input  logic [VEC_W-1:0]  vec,
   output logic [ADDR_W-1:0] addr
);
   localparam int PAD_W = ADDR_W - VEC_W;

   generate
      if (VEC_W > ADDR_W) begin : g_bad_width
         $error("vector wider than address");
      end
      if (TABLE_BASE == 0) begin : g_zero_base
         assign addr = {{PAD_W{1'b0}}, vec};
      end else begin : g_offset_base
         localparam logic [ADDR_W-1:0] BASE = ADDR_W'(TABLE_BASE);
         assign addr = BASE + {{PAD_W{1'b0}}, vec};
      end
   endgenerate
endmodule

// File: rtl/tseq_ctrl.sv
module tseq_ctrl
   import trapseq_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        trap_start,
   input  logic        ret_start,
   input  logic        mem_valid,
   output tseq_state_e state,
   output logic        take_trap,
   output logic        take_ret,
   output logic        take_fetch
);
   tseq_state_e nxt;

   assign take_trap  = (state == ST_IDLE) && trap_start;
   assign take_ret   = (state == ST_IDLE) && ret_start && !trap_start;
   assign take_fetch = (state == ST_WAIT) && mem_valid;

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE: if (take_trap) nxt = ST_REQ;
                  else if (take_ret) nxt = ST_JUMP;
         ST_REQ:  nxt = ST_WAIT;
         ST_WAIT: if (take_fetch) nxt = ST_LINK;
         ST_LINK: nxt = ST_DONE;
         ST_JUMP: nxt = ST_DONE;
         ST_DONE: nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   // R3: a wait cycle without valid stays in wait
   a_r3_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && !mem_valid) |=> (state == ST_WAIT));
   // R7: a busy state never returns to request without passing idle
   a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) |=> (state != ST_REQ));
endmodule

// File: rtl/tseq_hold.sv
module tseq_hold #(
   parameter int VEC_W  = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take_trap,
   input  logic              take_ret,
   input  logic              take_fetch,
   input  logic              hold_chk,
   input  logic [VEC_W-1:0]  vec_in,
   input  logic [DATA_W-1:0] pc_in,
   input  logic [DATA_W-1:0] r7_in,
   input  logic [DATA_W-1:0] rdata_in,
   output logic [VEC_W-1:0]  vec_q,
   output logic [DATA_W-1:0] link_q,
   output logic [DATA_W-1:0] target_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_q    <= '0;
         link_q   <= '0;
         target_q <= '0;
      end else begin
         if (take_trap) begin
            vec_q  <= vec_in;
            link_q <= pc_in;
         end
         if (take_ret)   target_q <= r7_in;
         if (take_fetch) target_q <= rdata_in;
      end
   end

   // R10: link address untouched while the table read is outstanding
   a_r10_link_stable: assert property (@(posedge clk) disable iff (!rst_n)
      hold_chk |=> $stable(link_q));
endmodule

// File: rtl/trap_dispatch_seq.sv
module trap_dispatch_seq
   import trapseq_pkg::*;
#(
   parameter int VEC_W      = 8,
   parameter int DATA_W     = 16,
   parameter int REG_IDX_W  = 3,
   parameter int LINK_REG   = 7,
   parameter int TABLE_BASE = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 trap_start,
   input  logic [VEC_W-1:0]     trap_vec,
   input  logic [DATA_W-1:0]    pc_next,
   input  logic                 ret_start,
   input  logic [DATA_W-1:0]    r7_val,
   output logic                 mem_req,
   output logic [DATA_W-1:0]    mem_addr,
   input  logic                 mem_valid,
   input  logic [DATA_W-1:0]    mem_rdata,
   output logic                 reg_we,
   output logic [REG_IDX_W-1:0] reg_waddr,
   output logic [DATA_W-1:0]    reg_wdata,
   output logic                 pc_ld,
   output logic [DATA_W-1:0]    pc_val,
   output logic                 busy,
   output logic                 done
);
   localparam logic [REG_IDX_W-1:0] LINK_IDX = REG_IDX_W'(LINK_REG);

   generate
      if (LINK_REG >= (1 << REG_IDX_W)) begin : g_bad_link
         $error("link register index out of range");
      end
   endgenerate

   tseq_state_e          state;
   logic                 take_trap, take_ret, take_fetch;
   logic [VEC_W-1:0]     vec_q;
   logic [DATA_W-1:0]    link_q, target_q;

   tseq_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .trap_start (trap_start),
      .ret_start  (ret_start),
      .mem_valid  (mem_valid),
      .state      (state),
      .take_trap  (take_trap),
      .take_ret   (take_ret),
      .take_fetch (take_fetch)
   );

   tseq_hold #(.VEC_W(VEC_W), .DATA_W(DATA_W)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .take_trap  (take_trap),
      .take_ret   (take_ret),
      .take_fetch (take_fetch),
      .hold_chk   (state == ST_WAIT),
      .vec_in     (trap_vec),
      .pc_in      (pc_next),
      .r7_in      (r7_val),
      .rdata_in   (mem_rdata),
      .vec_q      (vec_q),
      .link_q     (link_q),
      .target_q   (target_q)
   );

   tseq_vec_addr #(.VEC_W(VEC_W), .ADDR_W(DATA_W), .TABLE_BASE(TABLE_BASE)) u_addr (
      .vec  (vec_q),
      .addr (mem_addr)
   );

   assign mem_req   = (state == ST_REQ);
   assign reg_we    = (state == ST_LINK);
   assign reg_waddr = LINK_IDX;
   assign reg_wdata = link_q;
   assign pc_ld     = (state == ST_LINK) || (state == ST_JUMP);
   assign pc_val    = target_q;
   assign busy      = (state != ST_IDLE);
   assign done      = (state == ST_DONE);

   // R2: request lasts a single cycle
   a_r2_req_single: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);
   // R4: every register write is the link write paired with a PC load
   a_r4_link_pair: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> (pc_ld && reg_waddr == LINK_IDX));
   // R5: completion follows every PC load
   a_r5_done_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      pc_ld |=> (done && !pc_ld));
   // R6: request only while busy
   a_r6_busy_on_req: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);
   // R5/R6: idle after done
   a_r6_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
endmodule

// File: tb/trap_dispatch_seq_bench.sv
module trap_dispatch_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trap_start = 1'b0;
   logic [7:0]  trap_vec = '0;
   logic [15:0] pc_next = '0;
   logic        ret_start = 1'b0;
   logic [15:0] r7_val = '0;
   logic        mem_req;
   logic [15:0] mem_addr;
   logic        mem_valid = 1'b0;
   logic [15:0] mem_rdata = '0;
   logic        reg_we;
   logic [2:0]  reg_waddr;
   logic [15:0] reg_wdata;
   logic        pc_ld;
   logic [15:0] pc_val;
   logic        busy;
   logic        done;

   int total = 0, bad = 0;
   int mem_lat = 0, mem_cnt = 0, req_seen = 0;
   bit mem_pend = 0, finished = 0;
   int m_ph = 0;           // 0 idle 1 req 2 wait 3 link 4 jump 5 done
   int m_pc = 0, m_vec = 0, m_tgt = 0;

   always #2 clk = ~clk;

   trap_dispatch_seq u_trap_dispatch_seq (
      .clk(clk), .rst_n(rst_n), .trap_start(trap_start), .trap_vec(trap_vec),
      .pc_next(pc_next), .ret_start(ret_start), .r7_val(r7_val),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
      .mem_rdata(mem_rdata), .reg_we(reg_we), .reg_waddr(reg_waddr),
      .reg_wdata(reg_wdata), .pc_ld(pc_ld), .pc_val(pc_val),
      .busy(busy), .done(done));

   function automatic int table_word(int a);
      return (16'h4000 + a * 37) & 16'hFFFF;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference, advanced on every rising edge
   always @(posedge clk) begin
      if (!rst_n) m_ph = 0;
      else case (m_ph)
         0: if (trap_start) begin m_ph = 1; m_pc = pc_next; m_vec = trap_vec; end
            else if (ret_start) begin m_ph = 4; m_tgt = r7_val; end
         1: m_ph = 2;
         2: if (mem_valid) begin m_tgt = mem_rdata; m_ph = 3; end
         3: m_ph = 5;
         4: m_ph = 5;
         default: m_ph = 0;
      endcase
   end

   // comparison on every cycle, away from the rising edge
   always @(negedge clk) if (rst_n && !finished) begin
      chk(busy == (m_ph != 0), "R6 busy", busy, m_ph != 0);
      chk(mem_req == (m_ph == 1), "R2 mem_req", mem_req, m_ph == 1);
      if (m_ph == 1) chk(mem_addr == m_vec, "R2 mem_addr", mem_addr, m_vec);
      if (m_ph == 2) chk(!pc_ld && !reg_we && !done, "R3 quiet wait", {pc_ld, reg_we, done}, 0);
      chk(reg_we == (m_ph == 3), "R4 reg_we", reg_we, m_ph == 3);
      if (m_ph == 3) begin
         chk(reg_waddr == 3'd7, "R4 reg_waddr", reg_waddr, 7);
         chk(reg_wdata == m_pc, "R10 reg_wdata", reg_wdata, m_pc);
      end
      chk(pc_ld == (m_ph == 3 || m_ph == 4), "R4 pc_ld", pc_ld, m_ph == 3 || m_ph == 4);
      if (m_ph == 3 || m_ph == 4) chk(pc_val == m_tgt, m_ph == 4 ? "R8 pc_val" : "R4 pc_val", pc_val, m_tgt);
      chk(done == (m_ph == 5), "R5 done", done, m_ph == 5);
   end

   // memory responder: table word after mem_lat extra cycles
   always @(negedge clk) begin
      mem_valid <= 1'b0;
      if (mem_pend) begin
         if (mem_cnt == 0) begin
            mem_valid <= 1'b1;
            mem_rdata <= 16'(table_word(int'(mem_addr)));
            mem_pend  <= 0;
         end else mem_cnt <= mem_cnt - 1;
      end
      if (mem_req) begin
         mem_pend <= 1; mem_cnt <= mem_lat; req_seen <= req_seen + 1;
      end
   end

   task automatic wait_done();
      while (!done) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic pulse(input bit t, input bit r, input logic [7:0] v,
                        input logic [15:0] pc, input logic [15:0] r7);
      trap_start = t; ret_start = r; trap_vec = v; pc_next = pc; r7_val = r7;
      @(negedge clk);
      trap_start = 0; ret_start = 0;
   endtask

   task automatic report();
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(4 * 200000);
      chk(0, "watchdog", 0, 1);
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({busy, done, mem_req, reg_we, pc_ld} == 0, "R1 reset", {busy, done, mem_req, reg_we, pc_ld}, 0);
      rst_n = 1;
      @(negedge clk);
      chk(!busy, "R1 idle after reset", busy, 0);

      // lowest table entry, immediate memory
      mem_lat = 0; req_seen = 0;
      pulse(1, 0, 8'h00, 16'h3001, 16'h0);
      wait_done();
      chk(req_seen == 1, "R2 one request", req_seen, 1);

      // highest entry, slow memory, disturbances mid-sequence (R7, R10)
      mem_lat = 3; req_seen = 0;
      pulse(1, 0, 8'hFF, 16'h3100, 16'h0);
      pc_next = 16'hBEEF;
      pulse(1, 1, 8'h12, 16'h7777, 16'h5555);
      wait_done();
      chk(req_seen == 1, "R7 ignored start", req_seen, 1);

      // return through register 7 (R8), repeated return while busy (R7)
      req_seen = 0;
      pulse(0, 1, 8'h00, 16'h0, 16'h3005);
      pulse(0, 1, 8'h00, 16'h0, 16'h9999);
      wait_done();
      chk(req_seen == 0, "R8 no memory read", req_seen, 0);

      // simultaneous trap and return (R9)
      mem_lat = 1; req_seen = 0;
      pulse(1, 1, 8'h25, 16'h3200, 16'h1234);
      wait_done();
      chk(req_seen == 1, "R9 trap wins", req_seen, 1);

      // long wait (R3)
      mem_lat = 6; req_seen = 0;
      pulse(1, 0, 8'h21, 16'h30A0, 16'h0);
      wait_done();
      chk(req_seen == 1, "R3 long wait", req_seen, 1);

      repeat (3) @(negedge clk);
      report();
   end
endmodule